// File: doc/BRIEF.md
# Time-of-Day and Calendar Update Engine

This block holds a time of day and a century calendar as ten byte registers and advances them by one second each time a one-second strobe arrives from a prescaler. A strobe raises a busy status. A short lead window follows, then a single commit cycle writes the advanced time into the working copy. At the same point it ends the busy status, emits an update-ended pulse and, if the new time meets the alarm setting, an alarm pulse.

Two copies of the ten bytes exist. The working copy always advances. The host-visible copy takes each new value only while the freeze input is low. Each byte is held as either packed BCD or plain binary. Hours can be counted over 24 or as 1 to 12 with a PM flag. When enabled, two fixed daylight-saving jumps are applied. Host writes go to both copies at once, and reads return the host-visible copy.

Top module: `rtc_update_engine`

## Requirements
- R1: Byte addresses are 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday (1 = Sunday, 7 = Saturday), 7 day of month, 8 month, 9 year 0-99. A write to addresses 0-9 lands in both copies. Writes to addresses 10-15 are dropped, and reads there return 00.
- R2: Each update adds one second. Seconds and minutes wrap 59 to 0 and carry upward. Hours wrap at the end of the day.
- R3: At the day wrap the weekday steps 7 to 1 and the day of month returns to 1 after 30 days (months 4, 6, 9, 11), 31 days (other months), or for month 2 after 29 days when year mod 4 is 0 and after 28 days otherwise. Month wraps 12 to 1 and year wraps 99 to 0.
- R4: With fmt_bin = 1 every byte is plain binary, and with fmt_bin = 0 every byte is packed BCD (tens in bits 7:4).
- R5: With hr24 = 0 the hour byte holds 1-12 in its low seven bits, with bit 7 = 1 meaning PM. 11 AM is followed by 12 PM, 12 PM by 1 PM, and 11 PM by 12 AM with a day wrap.
- R6: alarm_hit pulses together with upd_done when seconds, minutes and hours each equal their alarm byte. An alarm byte with bits 7:6 = 11 matches any value, and a byte with only bit 7 set does not.
- R7: While inhibit = 1 the host-visible copy does not change on updates, but the working copy still advances. The next update after inhibit returns to 0 shows all the seconds that elapsed.
- R8: A sec_tick puts the block into a busy window of LEAD_CYC+1 clocks. uip is high through that window, unless inhibit = 1, in which case uip reads 0. The cycle in which upd_done pulses has uip low.
- R9: With dst_en = 1, on a Sunday in April with day of month 1-7, the update from 1:59:59 gives 3:00:00. On any other day it gives 2:00:00.
- R10: With dst_en = 1, on a Sunday in October with day of month 25 or later, the first update from 1:59:59 gives 1:00:00. A second pass through 1:59:59 that same day gives 2:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all bytes and state |
| sec_tick | input | 1 | One-cycle one-second strobe |
| fmt_bin | input | 1 | 1 = binary bytes, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| inhibit | input | 1 | Freezes the host-visible copy |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 8 | Host-visible byte at rd_addr |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse when an update ends |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The October fall-back is the hardest case to reach. It depends on a hidden once-per-day flag, and that flag only shows up on a second pass through 1:59:59 on the same Sunday. The stimulus writes 1:59:59 on a late-October Sunday, checks the fall to 1:00:00, and then writes 1:59:59 again without a day wrap in between, expecting 2:00:00. The frozen-copy case is reached in a similar way: the bench holds inhibit over several strobes, then releases it and expects the seconds that accumulated.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NBYTES    = 10;
    localparam int IX_SEC    = 0;
    localparam int IX_SEC_AL = 1;
    localparam int IX_MIN    = 2;
    localparam int IX_MIN_AL = 3;
    localparam int IX_HR     = 4;
    localparam int IX_HR_AL  = 5;
    localparam int IX_DOW    = 6;
    localparam int IX_DOM    = 7;
    localparam int IX_MON    = 8;
    localparam int IX_YR     = 9;

    typedef logic [7:0] byte_t;
    typedef logic [NBYTES-1:0][7:0] bank_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_COMMIT = 2'd2
    } phase_e;

    // Stored byte to plain value
    function automatic byte_t to_val(byte_t raw, logic bin_mode);
        byte_t tens;
        tens = {4'b0000, raw[7:4]} * 8'd10;
        return bin_mode ? raw : byte_t'(tens + {4'b0000, raw[3:0]});
    endfunction

    // Plain value to stored byte
    function automatic byte_t to_raw(byte_t v, logic bin_mode);
        byte_t tens;
        byte_t ones;
        tens = v / 8'd10;
        ones = v - tens * 8'd10;
        return bin_mode ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic byte_t month_len(byte_t mon, byte_t yr);
        byte_t len;
        case (mon)
            8'd4, 8'd6, 8'd9, 8'd11: len = 8'd30;
            8'd2:                    len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 len = 8'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_time_step.sv
module rtc_time_step
    import rtc_cal_pkg::*;
(
    input  bank_t cur_i,
    input  logic  fmt_bin,
    input  logic  hr24,
    input  logic  dst_en,
    input  logic  fell_i,
    output bank_t nxt_o,
    output logic  fell_o
);

    byte_t s_v, m_v, h_v, dw_v, dm_v, mo_v, yr_v, h12_v;
    byte_t ns_v, nm_v, nh_v, ndw_v, ndm_v, nmo_v, nyr_v, nh12_v, hr_enc;
    logic  pm_in, pm_out, at_159, spring, fall;

    always_comb begin
        // decode the working bytes into plain values
        s_v   = to_val(cur_i[IX_SEC], fmt_bin);
        m_v   = to_val(cur_i[IX_MIN], fmt_bin);
        dw_v  = to_val(cur_i[IX_DOW], fmt_bin);
        dm_v  = to_val(cur_i[IX_DOM], fmt_bin);
        mo_v  = to_val(cur_i[IX_MON], fmt_bin);
        yr_v  = to_val(cur_i[IX_YR],  fmt_bin);
        pm_in = cur_i[IX_HR][7];
        h12_v = to_val({1'b0, cur_i[IX_HR][6:0]}, fmt_bin);
        if (hr24) begin
            h_v = to_val(cur_i[IX_HR], fmt_bin);
        end else if (h12_v == 8'd12) begin
            h_v = pm_in ? 8'd12 : 8'd0;
        end else begin
            h_v = h12_v + (pm_in ? 8'd12 : 8'd0);
        end

        at_159 = (h_v == 8'd1) && (m_v == 8'd59) && (s_v == 8'd59);
        spring = dst_en && at_159 && (mo_v == 8'd4) && (dw_v == 8'd1) && (dm_v <= 8'd7);
        fall   = dst_en && at_159 && (mo_v == 8'd10) && (dw_v == 8'd1) && (dm_v >= 8'd25)
                 && !fell_i;

        ns_v   = s_v + 8'd1;
        nm_v   = m_v;
        nh_v   = h_v;
        ndw_v  = dw_v;
        ndm_v  = dm_v;
        nmo_v  = mo_v;
        nyr_v  = yr_v;
        fell_o = fell_i;

        if (spring) begin
            ns_v = 8'd0;
            nm_v = 8'd0;
            nh_v = 8'd3;
        end else if (fall) begin
            ns_v   = 8'd0;
            nm_v   = 8'd0;
            nh_v   = 8'd1;
            fell_o = 1'b1;
        end else if (s_v >= 8'd59) begin
            ns_v = 8'd0;
            nm_v = m_v + 8'd1;
            if (m_v >= 8'd59) begin
                nm_v = 8'd0;
                nh_v = h_v + 8'd1;
                if (h_v >= 8'd23) begin
                    nh_v   = 8'd0;
                    fell_o = 1'b0;
                    ndw_v  = (dw_v >= 8'd7) ? 8'd1 : dw_v + 8'd1;
                    if (dm_v >= month_len(mo_v, yr_v)) begin
                        ndm_v = 8'd1;
                        nmo_v = mo_v + 8'd1;
                        if (mo_v >= 8'd12) begin
                            nmo_v = 8'd1;
                            nyr_v = (yr_v >= 8'd99) ? 8'd0 : yr_v + 8'd1;
                        end
                    end else begin
                        ndm_v = dm_v + 8'd1;
                    end
                end
            end
        end

        // encode the hour in the selected style
        pm_out = (nh_v >= 8'd12);
        if (nh_v == 8'd0) begin
            nh12_v = 8'd12;
        end else if (nh_v > 8'd12) begin
            nh12_v = nh_v - 8'd12;
        end else begin
            nh12_v = nh_v;
        end
        hr_enc = to_raw(nh12_v, fmt_bin);
        hr_enc = {pm_out, hr_enc[6:0]};

        nxt_o         = cur_i;
        nxt_o[IX_SEC] = to_raw(ns_v, fmt_bin);
        nxt_o[IX_MIN] = to_raw(nm_v, fmt_bin);
        nxt_o[IX_HR]  = hr24 ? to_raw(nh_v, fmt_bin) : hr_enc;
        nxt_o[IX_DOW] = to_raw(ndw_v, fmt_bin);
        nxt_o[IX_DOM] = to_raw(ndm_v, fmt_bin);
        nxt_o[IX_MON] = to_raw(nmo_v, fmt_bin);
        nxt_o[IX_YR]  = to_raw(nyr_v, fmt_bin);
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_cal_pkg::*;
#(
    parameter int NPAIR = 3
) (
    input  bank_t bytes_i,
    output logic  match_o
);

    logic [NPAIR-1:0] pair_ok;

    // time byte at even address 2g, its alarm byte at 2g+1
    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        assign pair_ok[g] = (bytes_i[2*g+1][7:6] == 2'b11) ||
                            (bytes_i[2*g+1] == bytes_i[2*g]);
    end

    assign match_o = &pair_ok;

endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
    import rtc_cal_pkg::*;
#(
    parameter int LEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       fmt_bin,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       inhibit,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       uip,
    output logic       upd_done,
    output logic       alarm_hit
);

    localparam int          CW        = (LEAD_CYC > 1) ? $clog2(LEAD_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEAD_CYC - 1);
    localparam logic [3:0]  LAST_ADDR = 4'(NBYTES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        bank_t         live;
        bank_t         shown;
        logic          fell;
        logic          done;
        logic          hit;
    } eng_s;

    eng_s  st_d, st_q;
    bank_t nxt_bank;
    logic  fell_nxt;
    logic  al_match;
    logic  busy;

    rtc_time_step u_step (
        .cur_i   (st_q.live),
        .fmt_bin (fmt_bin),
        .hr24    (hr24),
        .dst_en  (dst_en),
        .fell_i  (st_q.fell),
        .nxt_o   (nxt_bank),
        .fell_o  (fell_nxt)
    );

    rtc_alarm_cmp #(.NPAIR(3)) u_alarm (
        .bytes_i (nxt_bank),
        .match_o (al_match)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.hit  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (sec_tick) begin
                    st_d.phase = PH_LEAD;
                    st_d.cnt   = '0;
                end
            end
            PH_LEAD: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_COMMIT;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_COMMIT: begin
                st_d.live  = nxt_bank;
                st_d.fell  = fell_nxt;
                if (!inhibit) begin
                    st_d.shown = nxt_bank;
                end
                st_d.done  = 1'b1;
                st_d.hit   = al_match;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (wr_en && (wr_addr <= LAST_ADDR)) begin
            st_d.live[wr_addr]  = wr_data;
            st_d.shown[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign uip       = busy && !inhibit;
    assign upd_done  = st_q.done;
    assign alarm_hit = st_q.hit;
    assign rd_data   = (rd_addr <= LAST_ADDR) ? st_q.shown[rd_addr] : 8'h00;

    // R8: a busy window only opens after a strobe
    a_r8_busy_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sec_tick));

    // R8: the update-ended pulse never overlaps the busy status
    a_r8_done_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !uip);

    // R6: alarm pulses only come with an update end
    a_r6_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);

    // R7: the host-visible copy holds while frozen and not written
    a_r7_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !wr_en) |=> $stable(st_q.shown));

endmodule

// File: tb/tb_rtc_update_engine.sv
module tb_rtc_update_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       fmt_bin = 1'b0;
    logic       hr24 = 1'b1;
    logic       dst_en = 1'b0;
    logic       inhibit = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       uip, upd_done, alarm_hit;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic hit_q[$];

    always #2.5 clk = ~clk;

    rtc_update_engine #(.LEAD_CYC(4)) dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .fmt_bin(fmt_bin),
        .hr24(hr24), .dst_en(dst_en), .inhibit(inhibit), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the expected alarm bit at every update end
    always @(negedge clk) begin
        if (rst_n && upd_done) begin
            if (hit_q.size() == 0) begin
                chk("R6 unexpected update", 8'h01, 8'h00);
            end else begin
                chk("R6 alarm pulse", {7'b0, alarm_hit}, {7'b0, hit_q.pop_front()});
            end
        end
    end

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(int a, logic [7:0] e, string req);
        rd_addr = 4'(a);
        #1;
        chk(req, rd_data, e);
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dw,
                            logic [7:0] dm, logic [7:0] mo, logic [7:0] yr);
        wr(0, s); wr(2, m); wr(4, h); wr(6, dw); wr(7, dm); wr(8, mo); wr(9, yr);
    endtask

    task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        wr(1, s); wr(3, m); wr(5, h);
    endtask

    // driver: pushes the expected alarm bit, strobes, waits for the end
    task automatic tick(logic exp_hit);
        hit_q.push_back(exp_hit);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R8 uip while busy", {7'b0, uip}, {7'b0, !inhibit});
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (upd_done) break;
        end
        chk("R8 update ended", {7'b0, upd_done}, 8'h01);
        chk("R8 uip low at end", {7'b0, uip}, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 reset uip", {7'b0, uip}, 8'h00);
        chk("R8 reset done", {7'b0, upd_done}, 8'h00);
        rd_exp(0, 8'h00, "R1 reset seconds");

        // R1 map and dropped addresses
        wr(1, 8'h45);
        rd_exp(1, 8'h45, "R1 alarm byte");
        wr(10, 8'h55);
        rd_exp(10, 8'h00, "R1 address 10 reads zero");
        wr(12, 8'h77);
        rd_exp(12, 8'h00, "R1 address 12 reads zero");
        rd_exp(2, 8'h00, "R1 stray write no effect");
        set_alarm(8'h45, 8'h45, 8'h45);

        // R2 R3 R4: BCD century wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick(1'b0);
        rd_exp(0, 8'h00, "R2 sec wrap");
        rd_exp(2, 8'h00, "R2 min wrap");
        rd_exp(4, 8'h00, "R2 hour wrap");
        rd_exp(6, 8'h01, "R3 weekday 7->1");
        rd_exp(7, 8'h01, "R3 dom wrap");
        rd_exp(8, 8'h01, "R3 month wrap");
        rd_exp(9, 8'h00, "R3 year 99->0");

        // R4 plain increment in BCD
        set_time(8'h09, 8'h15, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21);
        tick(1'b0);
        rd_exp(0, 8'h10, "R4 BCD digit carry");

        // R3 R4 binary February
        fmt_bin = 1'b1;
        set_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h01);
        tick(1'b0);
        rd_exp(7, 8'h01, "R3 Feb 28 non-leap");
        rd_exp(8, 8'h03, "R3 month to March");
        rd_exp(6, 8'h04, "R3 weekday step");
        rd_exp(0, 8'h00, "R4 binary sec wrap");
        set_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h04);
        tick(1'b0);
        rd_exp(7, 8'h1D, "R3 Feb 29 leap");
        rd_exp(8, 8'h02, "R3 stays February");
        set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick(1'b0);
        rd_exp(0, 8'h0A, "R4 binary 9->10");

        // R3 30-day month in BCD
        fmt_bin = 1'b0;
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
        tick(1'b0);
        rd_exp(7, 8'h01, "R3 April 30 wrap");
        rd_exp(8, 8'h05, "R3 to May");

        // R5 12-hour BCD
        hr24 = 1'b0;
        set_time(8'h59, 8'h59, 8'h11, 8'h01, 8'h15, 8'h06, 8'h21);
        tick(1'b0);
        rd_exp(4, 8'h92, "R5 11AM->12PM");
        wr(0, 8'h59); wr(2, 8'h59);
        tick(1'b0);
        rd_exp(4, 8'h81, "R5 12PM->1PM");
        set_time(8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h06, 8'h21);
        tick(1'b0);
        rd_exp(4, 8'h12, "R5 11PM->12AM");
        rd_exp(7, 8'h16, "R5 day wrap at midnight");
        // R5 12-hour binary
        fmt_bin = 1'b1;
        set_time(8'h3B, 8'h3B, 8'h8B, 8'h01, 8'h0F, 8'h06, 8'h15);
        tick(1'b0);
        rd_exp(4, 8'h0C, "R5 binary 11PM->12AM");
        fmt_bin = 1'b0;
        hr24 = 1'b1;

        // R6 alarm cadence
        set_alarm(8'h05, 8'hC0, 8'hC0);
        set_time(8'h04, 8'h20, 8'h10, 8'h02, 8'h11, 8'h05, 8'h22);
        tick(1'b1);
        tick(1'b0);
        set_alarm(8'h85, 8'hC0, 8'hC0);
        wr(0, 8'h04);
        tick(1'b0);
        set_alarm(8'h00, 8'h30, 8'h10);
        set_time(8'h59, 8'h29, 8'h10, 8'h02, 8'h11, 8'h05, 8'h22);
        tick(1'b1);
        set_alarm(8'h45, 8'h45, 8'h45);

        // R7 freeze
        set_time(8'h00, 8'h00, 8'h10, 8'h02, 8'h11, 8'h05, 8'h22);
        @(negedge clk);
        inhibit = 1'b1;
        tick(1'b0);
        tick(1'b0);
        rd_exp(0, 8'h00, "R7 frozen copy");
        @(negedge clk);
        inhibit = 1'b0;
        tick(1'b0);
        rd_exp(0, 8'h03, "R7 working copy advanced");

        // R9 spring forward
        dst_en = 1'b1;
        set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h02, 8'h04, 8'h23);
        tick(1'b0);
        rd_exp(4, 8'h03, "R9 spring to 3AM");
        rd_exp(2, 8'h00, "R9 minutes zero");
        set_time(8'h59, 8'h59, 8'h01, 8'h02, 8'h03, 8'h04, 8'h23);
        tick(1'b0);
        rd_exp(4, 8'h02, "R9 not Sunday");

        // R10 fall back once
        set_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h29, 8'h10, 8'h23);
        tick(1'b0);
        rd_exp(4, 8'h01, "R10 fall to 1AM");
        rd_exp(0, 8'h00, "R10 seconds zero");
        wr(0, 8'h59); wr(2, 8'h59);
        tick(1'b0);
        rd_exp(4, 8'h02, "R10 second pass continues");
        dst_en = 1'b0;

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", 8'(hit_q.size()), 8'h00);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule